// File: doc/BRIEF.md
# Bulk Row Copy Command Sequencer

This block sits in a memory controller and turns one request to copy a DRAM row, or to clear a row to zero, into a short stream of DRAM commands. The array itself does the data movement. The sequencer only picks the right command pattern and spaces the commands out. The pattern depends on where the two rows sit:

- **Same subarray:** two back-to-back activates, so the shared row buffer carries the data.
- **Different banks:** a transfer-read from the source and a transfer-write to the destination over the internal I/O bus.
- **Different subarrays of one bank:** two such transfers through a scratch row.

A row is 8 KB. The sequencer never touches the data, so the row size sets no width here.

Clearing a row is a copy from a row that always holds zero. Each subarray has one scratch row and one zero row, set by configuration inputs. A programmable minimum gap is kept between commands to the same bank.

**Request port.** The request port is valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the cycle after `done`. The request fields need only be stable in the accepting cycle.

**Command port.** The command port is valid/ready. A command issues on a cycle where `cmd_valid` and `cmd_ready` are both high. While `cmd_valid` is high and `cmd_ready` is low, the command and its address hold steady.

Top module: `rowcopy_seq`

## Requirements
- R1: `req_ready` is high only while the block is idle. It drops in the cycle after a request is accepted. It returns high in the cycle after `done`. `cmd_valid` is never high while `req_ready` is high.
- R2: When source and destination share bank and subarray, the commands are: ACT source, ACT destination, PRE destination. Command codes: ACT=0, PRE=1, transfer-read XRD=2, transfer-write XWR=3.
- R3: When the banks differ, the commands are: ACT source, ACT destination, XRD source, XWR destination, PRE source bank, PRE destination bank.
- R4: When the bank matches but the subarrays differ, the scratch row T of the destination subarray, in the destination bank, is used. The commands are: ACT src, ACT T, XRD src, XWR T, PRE T, ACT T, ACT dst, XRD T, XWR dst, PRE dst.
- R5: A zero request ignores the source fields. It copies from the zero row of the destination's subarray in the destination bank, using the R2 pattern.
- R6: Two commands to the same bank issue at least max(`cfg_gap`,1) cycles apart. With `cmd_ready` held high, a step waits exactly until that bound. Commands to another bank are not held by this bank's gap.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op`, `cmd_bank`, `cmd_sa` and `cmd_row` stay unchanged into the next cycle.
- R8: `done` is a one-cycle pulse in the cycle right after the final precharge issues.
- R9: A request whose effective source equals its destination issues no command. It pulses `done` in the cycle after acceptance, with `err` low.
- R10: A request is rejected if its destination row equals the scratch row or the zero row of its subarray. A rejected request issues no command and pulses `done` with `err` high in the cycle after acceptance. `err` is never high without `done`.
- R11: After reset, `req_ready` is high and `cmd_valid`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_zero | input | 1 | 1 = clear destination, 0 = copy |
| req_src_bank | input | BANK_W | Source bank |
| req_src_sa | input | SA_W | Source subarray |
| req_src_row | input | ROW_W | Source row within subarray |
| req_dst_bank | input | BANK_W | Destination bank |
| req_dst_sa | input | SA_W | Destination subarray |
| req_dst_row | input | ROW_W | Destination row within subarray |
| cfg_gap | input | GAP_W | Minimum same-bank command spacing in cycles |
| cfg_temp_rows | input | SUBARRAYS*ROW_W | Scratch row per subarray, subarray i at bits [i*ROW_W +: ROW_W] |
| cfg_zero_rows | input | SUBARRAYS*ROW_W | Zero row per subarray, same packing |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted by the DRAM interface |
| cmd_op | output | 2 | Command code (R2) |
| cmd_bank | output | BANK_W | Command bank |
| cmd_sa | output | SA_W | Command subarray |
| cmd_row | output | ROW_W | Command row |
| done | output | 1 | Request finished, one-cycle pulse |
| err | output | 1 | Request rejected, valid with done |

## Verification
Each placement case gets its own request, and the full command list is compared entry by entry:

- The same-subarray case shows that no transfer is issued when the row buffer alone can move the data.
- The cross-bank case, run with a gap of four, shows by its issue cycles that the destination bank is not held by the source bank's counter.
- The cross-subarray case is run with stalls on the command port. It shows that the scratch row is chosen from the destination subarray and that a stalled command does not move.

Zero, same-row and reserved-row destinations are each sent once, to separate the paths that end without any command.

// File: rtl/rowcopy_pkg.sv
package rowcopy_pkg;

  typedef enum logic [1:0] {
    OP_ACT = 2'd0,
    OP_PRE = 2'd1,
    OP_XRD = 2'd2,
    OP_XWR = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    MODE_INTRA = 2'd0,
    MODE_BANK  = 2'd1,
    MODE_SUBA  = 2'd2
  } copy_mode_e;

  typedef enum logic [1:0] {
    SLOT_SRC = 2'd0,
    SLOT_DST = 2'd1,
    SLOT_TMP = 2'd2
  } slot_e;

  typedef struct packed {
    cmd_op_e op;
    slot_e   slot;
    logic    last;
  } step_t;

  localparam int STEP_W = 4;

  function automatic step_t mk(cmd_op_e o, slot_e s, logic l);
    step_t r;
    r.op = o;
    r.slot = s;
    r.last = l;
    return r;
  endfunction

  // Command program for each placement mode, one entry per step.
  function automatic step_t step_lookup(copy_mode_e m, logic [STEP_W-1:0] i);
    step_t r;
    r = mk(OP_PRE, SLOT_DST, 1'b1);
    case (m)
      MODE_INTRA: begin
        case (i)
          4'd0:    r = mk(OP_ACT, SLOT_SRC, 1'b0);
          4'd1:    r = mk(OP_ACT, SLOT_DST, 1'b0);
          default: r = mk(OP_PRE, SLOT_DST, 1'b1);
        endcase
      end
      MODE_BANK: begin
        case (i)
          4'd0:    r = mk(OP_ACT, SLOT_SRC, 1'b0);
          4'd1:    r = mk(OP_ACT, SLOT_DST, 1'b0);
          4'd2:    r = mk(OP_XRD, SLOT_SRC, 1'b0);
          4'd3:    r = mk(OP_XWR, SLOT_DST, 1'b0);
          4'd4:    r = mk(OP_PRE, SLOT_SRC, 1'b0);
          default: r = mk(OP_PRE, SLOT_DST, 1'b1);
        endcase
      end
      MODE_SUBA: begin
        case (i)
          4'd0:    r = mk(OP_ACT, SLOT_SRC, 1'b0);
          4'd1:    r = mk(OP_ACT, SLOT_TMP, 1'b0);
          4'd2:    r = mk(OP_XRD, SLOT_SRC, 1'b0);
          4'd3:    r = mk(OP_XWR, SLOT_TMP, 1'b0);
          4'd4:    r = mk(OP_PRE, SLOT_TMP, 1'b0);
          4'd5:    r = mk(OP_ACT, SLOT_TMP, 1'b0);
          4'd6:    r = mk(OP_ACT, SLOT_DST, 1'b0);
          4'd7:    r = mk(OP_XRD, SLOT_TMP, 1'b0);
          4'd8:    r = mk(OP_XWR, SLOT_DST, 1'b0);
          default: r = mk(OP_PRE, SLOT_DST, 1'b1);
        endcase
      end
      default: r = mk(OP_PRE, SLOT_DST, 1'b1);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rowcopy_classify.sv
module rowcopy_classify
  import rowcopy_pkg::*;
#(
  parameter int SUBARRAYS = 4,
  parameter int BANK_W    = 2,
  parameter int SA_W      = 2,
  parameter int ROW_W     = 6
) (
  input  logic                      zero,
  input  logic [BANK_W-1:0]         src_bank,
  input  logic [SA_W-1:0]           src_sa,
  input  logic [ROW_W-1:0]          src_row,
  input  logic [BANK_W-1:0]         dst_bank,
  input  logic [SA_W-1:0]           dst_sa,
  input  logic [ROW_W-1:0]          dst_row,
  input  logic [SUBARRAYS*ROW_W-1:0] temp_rows,
  input  logic [SUBARRAYS*ROW_W-1:0] zero_rows,
  output logic [BANK_W-1:0]         eff_src_bank,
  output logic [SA_W-1:0]           eff_src_sa,
  output logic [ROW_W-1:0]          eff_src_row,
  output logic [ROW_W-1:0]          tmp_row,
  output copy_mode_e                mode,
  output logic                      reject,
  output logic                      same
);

  logic [ROW_W-1:0] zrow;

  always_comb begin
    zrow    = zero_rows[dst_sa*ROW_W +: ROW_W];
    tmp_row = temp_rows[dst_sa*ROW_W +: ROW_W];

    if (zero) begin
      eff_src_bank = dst_bank;
      eff_src_sa   = dst_sa;
      eff_src_row  = zrow;
    end else begin
      eff_src_bank = src_bank;
      eff_src_sa   = src_sa;
      eff_src_row  = src_row;
    end

    reject = (dst_row == tmp_row) || (dst_row == zrow);
    same   = (eff_src_bank == dst_bank) && (eff_src_sa == dst_sa) &&
             (eff_src_row == dst_row);

    if (eff_src_bank != dst_bank) mode = MODE_BANK;
    else if (eff_src_sa != dst_sa) mode = MODE_SUBA;
    else                           mode = MODE_INTRA;
  end

endmodule

// File: rtl/rowcopy_gap.sv
module rowcopy_gap #(
  parameter int BANKS  = 4,
  parameter int BANK_W = 2,
  parameter int GAP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [BANK_W-1:0] issue_bank,
  input  logic [GAP_W-1:0]  gap,
  output logic [BANKS-1:0]  free
);

  logic [GAP_W-1:0] reload;
  assign reload = (gap == '0) ? '0 : gap - 1'b1;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [GAP_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
      end else if (issue && (issue_bank == BANK_W'(b))) begin
        cnt <= reload;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
    assign free[b] = (cnt == '0);
  end

endmodule

// File: rtl/rowcopy_seq.sv
module rowcopy_seq
  import rowcopy_pkg::*;
#(
  parameter int BANKS     = 4,
  parameter int SUBARRAYS = 4,
  parameter int ROW_W     = 6,
  parameter int GAP_W     = 4,
  localparam int BANK_W   = $clog2(BANKS),
  localparam int SA_W     = $clog2(SUBARRAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_zero,
  input  logic [BANK_W-1:0]          req_src_bank,
  input  logic [SA_W-1:0]            req_src_sa,
  input  logic [ROW_W-1:0]           req_src_row,
  input  logic [BANK_W-1:0]          req_dst_bank,
  input  logic [SA_W-1:0]            req_dst_sa,
  input  logic [ROW_W-1:0]           req_dst_row,
  input  logic [GAP_W-1:0]           cfg_gap,
  input  logic [SUBARRAYS*ROW_W-1:0] cfg_temp_rows,
  input  logic [SUBARRAYS*ROW_W-1:0] cfg_zero_rows,
  output logic                       cmd_valid,
  input  logic                       cmd_ready,
  output logic [1:0]                 cmd_op,
  output logic [BANK_W-1:0]          cmd_bank,
  output logic [SA_W-1:0]            cmd_sa,
  output logic [ROW_W-1:0]           cmd_row,
  output logic                       done,
  output logic                       err
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;

  state_e            st;
  copy_mode_e        mode_q;
  logic              err_q;
  logic [STEP_W-1:0] step_q;
  logic [BANK_W-1:0] s_bank, d_bank;
  logic [SA_W-1:0]   s_sa, d_sa;
  logic [ROW_W-1:0]  s_row, d_row, t_row;

  logic [BANK_W-1:0] c_src_bank;
  logic [SA_W-1:0]   c_src_sa;
  logic [ROW_W-1:0]  c_src_row, c_tmp_row;
  copy_mode_e        c_mode;
  logic              c_reject, c_same;

  rowcopy_classify #(
    .SUBARRAYS(SUBARRAYS), .BANK_W(BANK_W), .SA_W(SA_W), .ROW_W(ROW_W)
  ) u_classify (
    .zero(req_zero),
    .src_bank(req_src_bank), .src_sa(req_src_sa), .src_row(req_src_row),
    .dst_bank(req_dst_bank), .dst_sa(req_dst_sa), .dst_row(req_dst_row),
    .temp_rows(cfg_temp_rows), .zero_rows(cfg_zero_rows),
    .eff_src_bank(c_src_bank), .eff_src_sa(c_src_sa), .eff_src_row(c_src_row),
    .tmp_row(c_tmp_row), .mode(c_mode), .reject(c_reject), .same(c_same)
  );

  step_t             cur;
  logic [BANKS-1:0]  bank_free;
  logic              issue, accept;

  assign cur = step_lookup(mode_q, step_q);

  always_comb begin
    case (cur.slot)
      SLOT_SRC: begin cmd_bank = s_bank; cmd_sa = s_sa; cmd_row = s_row; end
      SLOT_TMP: begin cmd_bank = d_bank; cmd_sa = d_sa; cmd_row = t_row; end
      default:  begin cmd_bank = d_bank; cmd_sa = d_sa; cmd_row = d_row; end
    endcase
  end

  assign cmd_op    = cur.op;
  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign cmd_valid = (st == ST_RUN) && bank_free[cmd_bank];
  assign issue     = cmd_valid && cmd_ready;
  assign done      = (st == ST_DONE);
  assign err       = done && err_q;

  rowcopy_gap #(.BANKS(BANKS), .BANK_W(BANK_W), .GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_bank(cmd_bank),
    .gap(cfg_gap), .free(bank_free)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      err_q  <= 1'b0;
      step_q <= '0;
      mode_q <= MODE_INTRA;
      s_bank <= '0; s_sa <= '0; s_row <= '0;
      d_bank <= '0; d_sa <= '0; d_row <= '0; t_row <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept) begin
            s_bank <= c_src_bank; s_sa <= c_src_sa; s_row <= c_src_row;
            d_bank <= req_dst_bank; d_sa <= req_dst_sa; d_row <= req_dst_row;
            t_row  <= c_tmp_row;
            mode_q <= c_mode;
            step_q <= '0;
            err_q  <= c_reject;
            st     <= (c_reject || c_same) ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          if (issue) begin
            if (cur.last) st <= ST_DONE;
            else          step_q <= step_q + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rowcopy_seq_chk.sv
module rowcopy_seq_chk #(
  parameter int BANKS  = 4,
  parameter int BANK_W = 2,
  parameter int SA_W   = 2,
  parameter int ROW_W  = 6,
  parameter int GAP_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [SA_W-1:0]   cmd_sa,
  input logic [ROW_W-1:0]  cmd_row,
  input logic [GAP_W-1:0]  cfg_gap,
  input logic              done,
  input logic              err
);

  logic [GAP_W:0] since [BANKS];
  logic [GAP_W:0] eff_gap;
  logic           fire;

  assign fire    = cmd_valid && cmd_ready;
  assign eff_gap = (cfg_gap == '0) ? (GAP_W+1)'(1) : {1'b0, cfg_gap};

  always_ff @(posedge clk) begin
    for (int b = 0; b < BANKS; b++) begin
      if (!rst_n)                                   since[b] <= '1;
      else if (fire && (cmd_bank == BANK_W'(b)))    since[b] <= (GAP_W+1)'(1);
      else if (since[b] != '1)                      since[b] <= since[b] + 1'b1;
    end
  end

  assert_idle_no_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);

  assert_bank_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (since[cmd_bank] >= eff_gap));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) &&
      $stable(cmd_bank) && $stable(cmd_sa) && $stable(cmd_row)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

endmodule

bind rowcopy_seq rowcopy_seq_chk #(
  .BANKS(BANKS), .BANK_W(BANK_W), .SA_W(SA_W), .ROW_W(ROW_W), .GAP_W(GAP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_sa(cmd_sa),
  .cmd_row(cmd_row), .cfg_gap(cfg_gap), .done(done), .err(err)
);

// File: tb/rowcopy_seq_tb.sv
`timescale 1ns/1ps
module rowcopy_seq_tb;

  localparam int BANKS = 4, SUBARRAYS = 4, ROW_W = 6, GAP_W = 4;
  localparam int BANK_W = 2, SA_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_zero = 1'b0;
  logic [BANK_W-1:0] req_src_bank = '0, req_dst_bank = '0;
  logic [SA_W-1:0]   req_src_sa = '0, req_dst_sa = '0;
  logic [ROW_W-1:0]  req_src_row = '0, req_dst_row = '0;
  logic [GAP_W-1:0]  cfg_gap = '0;
  logic [SUBARRAYS*ROW_W-1:0] cfg_temp_rows, cfg_zero_rows;
  logic cmd_valid, cmd_ready = 1'b1;
  logic [1:0] cmd_op;
  logic [BANK_W-1:0] cmd_bank;
  logic [SA_W-1:0] cmd_sa;
  logic [ROW_W-1:0] cmd_row;
  logic done, err;

  always #2 clk = ~clk;

  rowcopy_seq #(.BANKS(BANKS), .SUBARRAYS(SUBARRAYS), .ROW_W(ROW_W), .GAP_W(GAP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_zero(req_zero), .req_src_bank(req_src_bank), .req_src_sa(req_src_sa),
    .req_src_row(req_src_row), .req_dst_bank(req_dst_bank), .req_dst_sa(req_dst_sa),
    .req_dst_row(req_dst_row), .cfg_gap(cfg_gap), .cfg_temp_rows(cfg_temp_rows),
    .cfg_zero_rows(cfg_zero_rows), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_sa(cmd_sa), .cmd_row(cmd_row),
    .done(done), .err(err)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit stall_en = 0;
  int n_cmd = 0, n_exp = 0;
  int l_code [32];
  int l_cyc  [32];
  int e_code [32];
  int done_cyc = -1, done_err = 0, stall_viol = 0;
  bit prev_stall = 0;
  int prev_code = 0;
  int acc_cyc = 0;

  function automatic int code(int op, int b, int s, int r);
    return op*100000 + b*10000 + s*1000 + r;
  endfunction

  // Monitor: drive cmd_ready just after the falling edge, then sample.
  always @(negedge clk) begin
    int c;
    cyc++;
    cmd_ready = stall_en ? ((cyc % 3) != 0) : 1'b1;
    #1;
    c = code(int'(cmd_op), int'(cmd_bank), int'(cmd_sa), int'(cmd_row));
    if (prev_stall && (!cmd_valid || c != prev_code)) stall_viol++;
    prev_stall = cmd_valid && !cmd_ready;
    prev_code  = c;
    if (cmd_valid && cmd_ready && n_cmd < 32) begin
      l_code[n_cmd] = c;
      l_cyc[n_cmd]  = cyc;
      n_cmd++;
    end
    if (done && done_cyc < 0) begin
      done_cyc = cyc;
      done_err = int'(err);
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic expect_cmd(int op, int b, int s, int r);
    e_code[n_exp] = code(op, b, s, r);
    n_exp++;
  endtask

  task automatic check_seq(string tag);
    bit ok = (n_cmd == n_exp);
    int bad = -1;
    for (int i = 0; i < n_exp && i < n_cmd; i++)
      if (bad < 0 && l_code[i] != e_code[i]) bad = i;
    if (bad >= 0) chk(1'b0, tag, $sformatf("command %0d", bad), l_code[bad], e_code[bad]);
    else          chk(ok, tag, "command count", n_cmd, n_exp);
  endtask

  task automatic run_req(bit z, int sb, int ss, int sr, int db, int ds, int dr,
                         int gap, bit stall);
    n_cmd = 0; n_exp = 0; done_cyc = -1; done_err = 0; stall_viol = 0;
    @(negedge clk);
    stall_en = stall;
    cfg_gap = GAP_W'(gap);
    req_zero = z;
    req_src_bank = BANK_W'(sb); req_src_sa = SA_W'(ss); req_src_row = ROW_W'(sr);
    req_dst_bank = BANK_W'(db); req_dst_sa = SA_W'(ds); req_dst_row = ROW_W'(dr);
    req_valid = 1'b1;
    #1.5;
    while (!req_ready) begin
      @(negedge clk); #1.5;
    end
    acc_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 300 && done_cyc < 0; i++) @(negedge clk);
    #1.5;
    stall_en = 0;
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R11", "req_ready after reset", int'(req_ready), 1);
    chk(cmd_valid == 1'b0, "R11", "cmd_valid after reset", int'(cmd_valid), 0);
    chk(done == 1'b0 && err == 1'b0, "R11", "done/err after reset", int'(done | err), 0);
  endtask

  task automatic t_intra;
    bit ready_busy;
    run_req(0, 0,1,5, 0,1,9, 3, 0);
    expect_cmd(0,0,1,5); expect_cmd(0,0,1,9); expect_cmd(1,0,1,9);
    check_seq("R2");
    chk(l_cyc[0] == acc_cyc + 1, "R1", "first command cycle", l_cyc[0], acc_cyc + 1);
    chk(l_cyc[1] - l_cyc[0] == 3 && l_cyc[2] - l_cyc[1] == 3, "R6",
        "same-bank spacing gap 3", l_cyc[2] - l_cyc[0], 6);
    chk(done_cyc == l_cyc[2] + 1, "R8", "done after last PRE", done_cyc, l_cyc[2] + 1);
    chk(done_err == 0, "R8", "err on good copy", done_err, 0);
    ready_busy = req_ready;
    chk(ready_busy == 1'b1, "R1", "req_ready back after done", int'(ready_busy), 1);
  endtask

  task automatic t_intra_gap0;
    run_req(0, 2,3,1, 2,3,2, 0, 0);
    expect_cmd(0,2,3,1); expect_cmd(0,2,3,2); expect_cmd(1,2,3,2);
    check_seq("R2");
    chk(l_cyc[1] - l_cyc[0] == 1 && l_cyc[2] - l_cyc[1] == 1, "R6",
        "gap 0 acts as 1", l_cyc[2] - l_cyc[0], 2);
  endtask

  task automatic t_bank;
    run_req(0, 1,0,3, 2,3,11, 4, 0);
    expect_cmd(0,1,0,3); expect_cmd(0,2,3,11); expect_cmd(2,1,0,3);
    expect_cmd(3,2,3,11); expect_cmd(1,1,0,3); expect_cmd(1,2,3,11);
    check_seq("R3");
    chk(l_cyc[1] - l_cyc[0] == 1, "R6", "other bank not delayed", l_cyc[1] - l_cyc[0], 1);
    chk(l_cyc[3] - l_cyc[0] == 5 && l_cyc[5] - l_cyc[0] == 9, "R6",
        "cross-bank issue cycles", l_cyc[5] - l_cyc[0], 9);
    chk(done_cyc == l_cyc[5] + 1, "R8", "done after last PRE", done_cyc, l_cyc[5] + 1);
  endtask

  task automatic t_suba;
    bit spaced = 1;
    run_req(0, 3,0,8, 3,2,20, 2, 1);
    expect_cmd(0,3,0,8);  expect_cmd(0,3,2,42); expect_cmd(2,3,0,8);
    expect_cmd(3,3,2,42); expect_cmd(1,3,2,42); expect_cmd(0,3,2,42);
    expect_cmd(0,3,2,20); expect_cmd(2,3,2,42); expect_cmd(3,3,2,20);
    expect_cmd(1,3,2,20);
    check_seq("R4");
    for (int i = 1; i < n_cmd; i++) if (l_cyc[i] - l_cyc[i-1] < 2) spaced = 0;
    chk(spaced, "R6", "spacing under stalls", int'(spaced), 1);
    chk(stall_viol == 0, "R7", "command moved while stalled", stall_viol, 0);
  endtask

  task automatic t_zero;
    run_req(1, 2,3,30, 1,2,7, 1, 0);
    expect_cmd(0,1,2,52); expect_cmd(0,1,2,7); expect_cmd(1,1,2,7);
    check_seq("R5");
    chk(done_err == 0, "R5", "err on clear", done_err, 0);
  endtask

  task automatic t_same;
    run_req(0, 2,1,15, 2,1,15, 3, 0);
    chk(n_cmd == 0, "R9", "commands for same row", n_cmd, 0);
    chk(done_cyc == acc_cyc + 1, "R9", "done cycle", done_cyc, acc_cyc + 1);
    chk(done_err == 0, "R9", "err for same row", done_err, 0);
  endtask

  task automatic t_reject;
    run_req(0, 0,0,4, 1,1,41, 2, 0);
    chk(n_cmd == 0, "R10", "commands when dst is scratch", n_cmd, 0);
    chk(done_cyc == acc_cyc + 1 && done_err == 1, "R10", "err when dst is scratch",
        done_err, 1);
    run_req(0, 0,0,4, 2,3,53, 2, 0);
    chk(n_cmd == 0, "R10", "commands when dst is zero row", n_cmd, 0);
    chk(done_cyc == acc_cyc + 1 && done_err == 1, "R10", "err when dst is zero row",
        done_err, 1);
  endtask

  task automatic finish_all;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < SUBARRAYS; i++) begin
      cfg_temp_rows[i*ROW_W +: ROW_W] = ROW_W'(40 + i);
      cfg_zero_rows[i*ROW_W +: ROW_W] = ROW_W'(50 + i);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1.5;
    t_reset();
    t_intra();
    t_intra_gap0();
    t_bank();
    t_suba();
    t_zero();
    t_same();
    t_reject();
    repeat (4) @(negedge clk);
    finish_all();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    finish_all();
  end

endmodule